// File: doc/BRIEF.md
# Load-Word Execute and Exception Unit

This unit carries out the word-load step of a 32-bit RISC pipeline. On an issue pulse it decodes the instruction word and adds the two register operands to form the effective address. It then checks that address for three kinds of fault in a fixed order: a missing address translation, a protection-zone violation, and a misaligned address. A clean access sends a one-cycle read strobe to a synchronous data memory. The returned word is passed to the register-file write port, either as it is or with its four bytes in reverse order.

A faulting access never reaches memory. In that case the unit raises a one-cycle exception pulse and provides the cause code and the exception-status fields that the cause defines. For the two translation-related faults it also provides the new machine-status mode bits. The translation lookup, the protection lookup, the register file and the status registers are all outside the unit. The unit receives lookup results as plain inputs and emits field values together with write enables. A parameter selects a result latency of one cycle or two cycles. A second parameter can disable the byte-reversing variant.

Top module: `lw_exec_unit`

## Requirements
- R1: The effective address is (opa_i + opb_i) modulo 2^32. On a clean access it appears on mem_addr_o, with mem_re_o high, in the same cycle as issue_i.
- R2: An instruction word is accepted only if bits [31:26] equal 6'b110010 and bits [9:0] are all zero. Bits [25:21] hold the destination index and bit 10 is the reverse flag. Any other word gives illegal_o and no memory read.
- R3: With the reverse flag at 0, the memory word is written to rf_wdata_o unchanged. With the flag at 1, byte 0 of the memory word lands in bits [31:24] of rf_wdata_o, byte 1 in [23:16], byte 2 in [15:8] and byte 3 in [7:0]. The write goes to the index on rf_waddr_o.
- R4: A translation miss while vm_i is 1 has the highest fault priority. It gives cause 5'b10010 and store indicator 0. A translation miss while vm_i is 0 is ignored.
- R5: A protection hit while both um_i and vm_i are 1 has the middle priority. It gives cause 5'b10000, store indicator 0, and zone indicator 0 with esr_diz_we_o high. A protection hit is ignored unless both bits are 1.
- R6: An address with either of its two lowest bits set has the lowest fault priority. It gives cause 5'b00001, word indicator 1, store indicator 0, and the destination index on esr_rx_o with esr_wrx_we_o high.
- R7: On a fault from R4 or R5, msr_we_o is high, msr_ums_o and msr_vms_o carry the um_i and vm_i values from issue time, and msr_um_o and msr_vm_o are 0. On a misaligned fault, msr_we_o stays low.
- R8: When an instruction faults, mem_re_o stays low and rf_we_o stays low. At most one of rf_we_o, exc_valid_o and illegal_o is high in any cycle.
- R9: All results (write-back, exception, illegal) appear LATENCY cycles after the issue cycle, where LATENCY is 1 or 2. Nothing appears earlier.
- R10: exc_valid_o, with esr_we_o, is a single-cycle pulse per faulting instruction. No output is raised while reset is held or while issue_i is low.
- R11: When REV_EN is 0, an instruction with the reverse flag set is reported on illegal_o. It causes no memory read, no register write and no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction issue strobe |
| instr_i | input | 32 | Instruction word |
| opa_i | input | 32 | First address operand |
| opb_i | input | 32 | Second address operand |
| um_i | input | 1 | Current user-mode bit |
| vm_i | input | 1 | Current virtual-mode bit |
| tlb_miss_i | input | 1 | No valid translation for the address |
| prot_hit_i | input | 1 | Access denied by zone protection |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 32 | Memory word address |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the strobe |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Destination register data |
| exc_valid_o | output | 1 | Exception pulse |
| esr_we_o | output | 1 | Exception cause and store indicator write |
| esr_ec_o | output | 5 | Exception cause code |
| esr_s_o | output | 1 | Store indicator value |
| esr_diz_we_o | output | 1 | Zone indicator write |
| esr_diz_o | output | 1 | Zone indicator value |
| esr_wrx_we_o | output | 1 | Word indicator and register index write |
| esr_w_o | output | 1 | Word indicator value |
| esr_rx_o | output | 5 | Faulting destination index |
| msr_we_o | output | 1 | Mode-bit write |
| msr_um_o | output | 1 | New user-mode bit |
| msr_vm_o | output | 1 | New virtual-mode bit |
| msr_ums_o | output | 1 | Saved user-mode bit |
| msr_vms_o | output | 1 | Saved virtual-mode bit |
| illegal_o | output | 1 | Illegal instruction pulse |

## Verification
The memory strobe and address are combinational with the issue, so the bench checks them one time step after driving, inside the issue cycle. Write-back, exception and illegal results are due exactly LATENCY clock edges after the issue edge. The bench drives on falling edges and reads the one-cycle instance on the next falling edge. It reads the two-cycle instance one falling edge later, after confirming that instance is still silent one edge earlier. On that later edge it also confirms that the one-cycle instance's pulses have already dropped.

// File: rtl/lw_exec_pkg.sv
package lw_exec_pkg;

  localparam logic [5:0] LW_OPCODE = 6'b110010;

  typedef enum logic [4:0] {
    EC_NONE  = 5'b00000,
    EC_ALIGN = 5'b00001,
    EC_PROT  = 5'b10000,
    EC_TLB   = 5'b10010
  } exc_code_e;

  // Control carried from issue to result
  typedef struct packed {
    logic      vld;
    logic      ill;
    logic      exc;
    exc_code_e ec;
    logic [4:0] rd;
    logic      rev;
    logic      um;
    logic      vm;
    logic      msr_upd;
    logic      diz_we;
    logic      wrx_we;
  } lw_ctl_t;

endpackage

// File: rtl/lw_decode_check.sv
module lw_decode_check
  import lw_exec_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter bit REV_EN    = 1'b1
) (
  input  logic              issue,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              um,
  input  logic              vm,
  input  logic              tlb_miss,
  input  logic              prot_hit,
  output logic [DATA_W-1:0] ea,
  output logic              rd_go,
  output lw_ctl_t           ctl
);

  localparam int OPC_LSB  = DATA_W - 6;
  localparam int RD_LSB   = OPC_LSB - REG_IDX_W;
  localparam int REV_BIT  = DATA_W - 22;
  localparam int ALIGN_W  = 2;

  logic fmt_ok, rev_flag, ill, tlb_f, prot_f, mis;
  logic unused_fields;

  assign ea            = opa + opb;
  assign rev_flag      = instr[REV_BIT];
  assign fmt_ok        = (instr[DATA_W-1:OPC_LSB] == LW_OPCODE) &&
                         (instr[REV_BIT-1:0] == '0);
  assign ill           = !fmt_ok || (rev_flag && !REV_EN);
  assign tlb_f         = tlb_miss && vm;
  assign prot_f        = prot_hit && um && vm;
  assign mis           = |ea[ALIGN_W-1:0];
  assign unused_fields = ^instr[RD_LSB-1:REV_BIT+1];

  assign rd_go = issue && !ill && !tlb_f && !prot_f && !mis;

  always_comb begin
    ctl     = '0;
    ctl.ec  = EC_NONE;
    ctl.vld = issue;
    ctl.rd  = instr[RD_LSB +: REG_IDX_W];
    ctl.rev = rev_flag;
    ctl.um  = um;
    ctl.vm  = vm;
    if (ill) begin
      ctl.ill = 1'b1;
    end else if (tlb_f) begin
      ctl.exc     = 1'b1;
      ctl.ec      = EC_TLB;
      ctl.msr_upd = 1'b1;
    end else if (prot_f) begin
      ctl.exc     = 1'b1;
      ctl.ec      = EC_PROT;
      ctl.msr_upd = 1'b1;
      ctl.diz_we  = 1'b1;
    end else if (mis) begin
      ctl.exc    = 1'b1;
      ctl.ec     = EC_ALIGN;
      ctl.wrx_we = 1'b1;
    end
  end

endmodule

// File: rtl/lw_byte_lane.sv
module lw_byte_lane #(
  parameter int DATA_W = 32
) (
  input  logic              rev,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] swapped;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign swapped[g*8 +: 8] = din[(NBYTES-1-g)*8 +: 8];
  end

  assign dout = rev ? swapped : din;

endmodule

// File: rtl/lw_pipe_reg.sv
module lw_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/lw_exec_unit.sv
module lw_exec_unit
  import lw_exec_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter int LATENCY   = 1,
  parameter bit REV_EN    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_i,
  input  logic [DATA_W-1:0]    instr_i,
  input  logic [DATA_W-1:0]    opa_i,
  input  logic [DATA_W-1:0]    opb_i,
  input  logic                 um_i,
  input  logic                 vm_i,
  input  logic                 tlb_miss_i,
  input  logic                 prot_hit_i,
  output logic                 mem_re_o,
  output logic [DATA_W-1:0]    mem_addr_o,
  input  logic [DATA_W-1:0]    mem_rdata_i,
  output logic                 rf_we_o,
  output logic [REG_IDX_W-1:0] rf_waddr_o,
  output logic [DATA_W-1:0]    rf_wdata_o,
  output logic                 exc_valid_o,
  output logic                 esr_we_o,
  output logic [4:0]           esr_ec_o,
  output logic                 esr_s_o,
  output logic                 esr_diz_we_o,
  output logic                 esr_diz_o,
  output logic                 esr_wrx_we_o,
  output logic                 esr_w_o,
  output logic [REG_IDX_W-1:0] esr_rx_o,
  output logic                 msr_we_o,
  output logic                 msr_um_o,
  output logic                 msr_vm_o,
  output logic                 msr_ums_o,
  output logic                 msr_vms_o,
  output logic                 illegal_o
);

  localparam int CTL_W = $bits(lw_ctl_t);
  localparam int RES_W = CTL_W + DATA_W;

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q, rst_sync_d;
  logic       run_ok;

  assign rst_sync_d = {rst_sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= rst_sync_d;
  end

  assign run_ok = rst_sync_q[1];

  // Issue stage
  logic              issue_ok, rd_go;
  logic [DATA_W-1:0] ea;
  lw_ctl_t           ctl_iss, ctl_s1;

  assign issue_ok = issue_i && run_ok;

  lw_decode_check #(
    .DATA_W    (DATA_W),
    .REG_IDX_W (REG_IDX_W),
    .REV_EN    (REV_EN)
  ) u_decode (
    .issue    (issue_ok),
    .instr    (instr_i),
    .opa      (opa_i),
    .opb      (opb_i),
    .um       (um_i),
    .vm       (vm_i),
    .tlb_miss (tlb_miss_i),
    .prot_hit (prot_hit_i),
    .ea       (ea),
    .rd_go    (rd_go),
    .ctl      (ctl_iss)
  );

  assign mem_re_o   = rd_go;
  assign mem_addr_o = ea;

  // Stage 1: control aligned with returning memory data
  logic s1_en;
  assign s1_en = issue_ok || ctl_s1.vld;

  lw_pipe_reg #(.W(CTL_W)) u_s1 (
    .clk   (clk),
    .rst_n (rst_sync_q[1]),
    .en    (s1_en),
    .d     (ctl_iss),
    .q     (ctl_s1)
  );

  logic [DATA_W-1:0] fmt_data;

  lw_byte_lane #(.DATA_W(DATA_W)) u_lane (
    .rev  (ctl_s1.rev),
    .din  (mem_rdata_i),
    .dout (fmt_data)
  );

  // Optional result stage
  lw_ctl_t           ctl_fin;
  logic [DATA_W-1:0] data_fin;

  if (LATENCY == 2) begin : g_lat2
    logic [RES_W-1:0] res_q;
    logic             s2_en;
    lw_ctl_t          ctl_s2;

    assign ctl_s2 = lw_ctl_t'(res_q[RES_W-1:DATA_W]);
    assign s2_en  = ctl_s1.vld || ctl_s2.vld;

    lw_pipe_reg #(.W(RES_W)) u_s2 (
      .clk   (clk),
      .rst_n (rst_sync_q[1]),
      .en    (s2_en),
      .d     ({ctl_s1, fmt_data}),
      .q     (res_q)
    );

    assign ctl_fin  = ctl_s2;
    assign data_fin = res_q[DATA_W-1:0];
  end else begin : g_lat1
    assign ctl_fin  = ctl_s1;
    assign data_fin = fmt_data;
  end

  // Result outputs
  logic exc_now;
  assign exc_now = ctl_fin.vld && ctl_fin.exc;

  assign rf_we_o      = ctl_fin.vld && !ctl_fin.ill && !ctl_fin.exc;
  assign rf_waddr_o   = ctl_fin.rd;
  assign rf_wdata_o   = data_fin;
  assign exc_valid_o  = exc_now;
  assign esr_we_o     = exc_now;
  assign esr_ec_o     = ctl_fin.ec;
  assign esr_s_o      = 1'b0;
  assign esr_diz_we_o = exc_now && ctl_fin.diz_we;
  assign esr_diz_o    = 1'b0;
  assign esr_wrx_we_o = exc_now && ctl_fin.wrx_we;
  assign esr_w_o      = 1'b1;
  assign esr_rx_o     = ctl_fin.rd;
  assign msr_we_o     = exc_now && ctl_fin.msr_upd;
  assign msr_um_o     = 1'b0;
  assign msr_vm_o     = 1'b0;
  assign msr_ums_o    = ctl_fin.um;
  assign msr_vms_o    = ctl_fin.vm;
  assign illegal_o    = ctl_fin.vld && ctl_fin.ill;

endmodule

// File: rtl/lw_exec_checker.sv
module lw_exec_checker #(
  parameter int LATENCY = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        issue_i,
  input logic [31:0] instr_i,
  input logic [31:0] opa_i,
  input logic [31:0] opb_i,
  input logic        vm_i,
  input logic        tlb_miss_i,
  input logic        mem_re_o,
  input logic [31:0] mem_addr_o,
  input logic        rf_we_o,
  input logic        exc_valid_o,
  input logic        illegal_o,
  input logic [4:0]  esr_ec_o,
  input logic        esr_wrx_we_o,
  input logic        msr_we_o
);

  p_addr_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |-> mem_addr_o == opa_i + opb_i);

  p_bad_opcode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && instr_i[31:26] != 6'b110010) |-> !mem_re_o);

  p_aligned_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |-> mem_addr_o[1:0] == 2'b00);

  p_align_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    esr_wrx_we_o |-> exc_valid_o && esr_ec_o == 5'b00001);

  p_msr_only_mmu_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msr_we_o |-> exc_valid_o && (esr_ec_o == 5'b10010 || esr_ec_o == 5'b10000));

  p_tlb_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && tlb_miss_i && vm_i) |-> !mem_re_o);

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we_o, exc_valid_o, illegal_o}));

  if (LATENCY == 2) begin : g_l2
    p_read_to_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re_o |=> ##1 rf_we_o);
  end else begin : g_l1
    p_read_to_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re_o |=> rf_we_o);
  end

endmodule

bind lw_exec_unit lw_exec_checker #(.LATENCY(LATENCY)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .issue_i      (issue_i),
  .instr_i      (instr_i),
  .opa_i        (opa_i),
  .opb_i        (opb_i),
  .vm_i         (vm_i),
  .tlb_miss_i   (tlb_miss_i),
  .mem_re_o     (mem_re_o),
  .mem_addr_o   (mem_addr_o),
  .rf_we_o      (rf_we_o),
  .exc_valid_o  (exc_valid_o),
  .illegal_o    (illegal_o),
  .esr_ec_o     (esr_ec_o),
  .esr_wrx_we_o (esr_wrx_we_o),
  .msr_we_o     (msr_we_o)
);

// File: tb/tb_lw_exec_unit.sv
module tb_lw_exec_unit;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, issue;
  logic [31:0] instr, opa, opb;
  logic        um, vm, tlb, prot;

  // Instance A: one-cycle latency, reverse allowed
  logic        re_a, rfwe_a, exc_a, esrwe_a, s_a, dizwe_a, diz_a, wrxwe_a, w_a;
  logic        msrwe_a, mum_a, mvm_a, ums_a, vms_a, ill_a;
  logic [31:0] addr_a, rdata_a, wdata_a;
  logic [4:0]  waddr_a, ec_a, rx_a;
  // Instance B: two-cycle latency, reverse disabled
  logic        re_b, rfwe_b, exc_b, esrwe_b, s_b, dizwe_b, diz_b, wrxwe_b, w_b;
  logic        msrwe_b, mum_b, mvm_b, ums_b, vms_b, ill_b;
  logic [31:0] addr_b, rdata_b, wdata_b;
  logic [4:0]  waddr_b, ec_b, rx_b;

  lw_exec_unit #(.LATENCY(1), .REV_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .instr_i(instr), .opa_i(opa), .opb_i(opb),
    .um_i(um), .vm_i(vm), .tlb_miss_i(tlb), .prot_hit_i(prot),
    .mem_re_o(re_a), .mem_addr_o(addr_a), .mem_rdata_i(rdata_a),
    .rf_we_o(rfwe_a), .rf_waddr_o(waddr_a), .rf_wdata_o(wdata_a),
    .exc_valid_o(exc_a), .esr_we_o(esrwe_a), .esr_ec_o(ec_a), .esr_s_o(s_a),
    .esr_diz_we_o(dizwe_a), .esr_diz_o(diz_a), .esr_wrx_we_o(wrxwe_a), .esr_w_o(w_a),
    .esr_rx_o(rx_a), .msr_we_o(msrwe_a), .msr_um_o(mum_a), .msr_vm_o(mvm_a),
    .msr_ums_o(ums_a), .msr_vms_o(vms_a), .illegal_o(ill_a));

  lw_exec_unit #(.LATENCY(2), .REV_EN(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .instr_i(instr), .opa_i(opa), .opb_i(opb),
    .um_i(um), .vm_i(vm), .tlb_miss_i(tlb), .prot_hit_i(prot),
    .mem_re_o(re_b), .mem_addr_o(addr_b), .mem_rdata_i(rdata_b),
    .rf_we_o(rfwe_b), .rf_waddr_o(waddr_b), .rf_wdata_o(wdata_b),
    .exc_valid_o(exc_b), .esr_we_o(esrwe_b), .esr_ec_o(ec_b), .esr_s_o(s_b),
    .esr_diz_we_o(dizwe_b), .esr_diz_o(diz_b), .esr_wrx_we_o(wrxwe_b), .esr_w_o(w_b),
    .esr_rx_o(rx_b), .msr_we_o(msrwe_b), .msr_um_o(mum_b), .msr_vm_o(mvm_b),
    .msr_ums_o(ums_b), .msr_vms_o(vms_b), .illegal_o(ill_b));

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h5A3C_96E1;
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  // Synchronous memory models
  always @(posedge clk) begin
    if (re_a) rdata_a <= memfn(addr_a);
    if (re_b) rdata_b <= memfn(addr_b);
  end

  // Observed results, with fields masked by their own enables
  logic [63:0] obs_a, obs_b;
  assign obs_a = {4'b0, rfwe_a, rfwe_a ? waddr_a : 5'd0, rfwe_a ? wdata_a : 32'd0,
                  exc_a, exc_a ? ec_a : 5'd0, exc_a & s_a, msrwe_a,
                  msrwe_a & ums_a, msrwe_a & vms_a, msrwe_a & mum_a, msrwe_a & mvm_a,
                  dizwe_a, dizwe_a & diz_a, wrxwe_a, wrxwe_a ? rx_a : 5'd0, wrxwe_a & w_a, ill_a};
  assign obs_b = {4'b0, rfwe_b, rfwe_b ? waddr_b : 5'd0, rfwe_b ? wdata_b : 32'd0,
                  exc_b, exc_b ? ec_b : 5'd0, exc_b & s_b, msrwe_b,
                  msrwe_b & ums_b, msrwe_b & vms_b, msrwe_b & mum_b, msrwe_b & mvm_b,
                  dizwe_b, dizwe_b & diz_b, wrxwe_b, wrxwe_b ? rx_b : 5'd0, wrxwe_b & w_b, ill_b};

  // Outcome classes: 0 write-back, 1 translation miss, 2 protection, 3 misaligned, 4 illegal
  function automatic logic [63:0] exp_obs(input int cls, input logic [4:0] rd,
                                          input logic [31:0] data, input logic cum, input logic cvm);
    logic [63:0] e;
    e = '0;
    case (cls)
      0: e = {4'b0, 1'b1, rd, data, 1'b0, 5'd0, 1'b0, 1'b0, 4'b0, 2'b0, 1'b0, 5'd0, 1'b0, 1'b0};
      1: e = {4'b0, 1'b0, 5'd0, 32'd0, 1'b1, 5'b10010, 1'b0, 1'b1, cum, cvm, 2'b00,
              2'b0, 1'b0, 5'd0, 1'b0, 1'b0};
      2: e = {4'b0, 1'b0, 5'd0, 32'd0, 1'b1, 5'b10000, 1'b0, 1'b1, cum, cvm, 2'b00,
              2'b10, 1'b0, 5'd0, 1'b0, 1'b0};
      3: e = {4'b0, 1'b0, 5'd0, 32'd0, 1'b1, 5'b00001, 1'b0, 1'b0, 4'b0,
              2'b0, 1'b1, rd, 1'b1, 1'b0};
      default: e = 64'd1;
    endcase
    return e;
  endfunction

  function automatic string tag_of(input int cls);
    case (cls)
      0: return "R3";
      1: return "R4 R7";
      2: return "R5 R7";
      3: return "R6";
      default: return "R11";
    endcase
  endfunction

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        rev;
    logic [4:0]  rd;
    logic        cum;
    logic        cvm;
    logic        ctlb;
    logic        cprot;
    logic [2:0]  cls;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_1000, 32'h0000_0024, 1'b0, 5'd3,  1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
    '{32'hFFFF_FFF0, 32'h0000_0020, 1'b1, 5'd7,  1'b0, 1'b0, 1'b0, 1'b0, 3'd0},
    '{32'h0000_0100, 32'h0000_0004, 1'b1, 5'd31, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0},
    '{32'h0000_2001, 32'h0000_0000, 1'b0, 5'd4,  1'b1, 1'b1, 1'b1, 1'b1, 3'd1},
    '{32'h0000_3000, 32'h0000_0008, 1'b0, 5'd5,  1'b1, 1'b0, 1'b1, 1'b1, 3'd0},
    '{32'h0000_4002, 32'h0000_0000, 1'b1, 5'd6,  1'b1, 1'b1, 1'b0, 1'b1, 3'd2},
    '{32'h0000_5000, 32'h0000_000C, 1'b0, 5'd8,  1'b0, 1'b1, 1'b0, 1'b1, 3'd0},
    '{32'h0000_1000, 32'h0000_0002, 1'b0, 5'd9,  1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{32'h0000_0000, 32'h0000_0001, 1'b1, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 3'd3},
    '{32'h0000_0001, 32'h0000_0002, 1'b0, 5'd10, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3},
    '{32'h0000_6000, 32'h0000_0010, 1'b0, 5'd11, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1}
  };

  function automatic logic [31:0] mk_instr(input logic [4:0] rd, input logic rev);
    return {6'b110010, rd, 5'd1, 5'd2, rev, 10'd0};
  endfunction

  task automatic idle_inputs();
    issue = 1'b0; instr = '0; opa = '0; opb = '0;
    um = 1'b0; vm = 1'b0; tlb = 1'b0; prot = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    issue = 1'b1; instr = mk_instr(5'd1, 1'b0); opa = 32'h40;
    #1;
    chk("R10 reset", {62'd0, re_a, re_b}, 64'd0);
    chk("R10 reset", obs_a | obs_b, 64'd0);
    idle_inputs();
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table walk
    for (int i = 0; i < NV; i++) begin
      logic [31:0] ea, dat;
      int          cls_b;
      ea  = VEC[i].a + VEC[i].b;
      dat = VEC[i].rev ? bswap(memfn(ea)) : memfn(ea);
      cls_b = VEC[i].rev ? 4 : int'(VEC[i].cls);
      issue = 1'b1; instr = mk_instr(VEC[i].rd, VEC[i].rev);
      opa = VEC[i].a; opb = VEC[i].b;
      um = VEC[i].cum; vm = VEC[i].cvm; tlb = VEC[i].ctlb; prot = VEC[i].cprot;
      #1;
      // R1 / R8: read strobe and address during the issue cycle
      chk("R1 R8 read", {31'd0, re_a, (re_a ? addr_a : 32'd0)},
          {31'd0, (VEC[i].cls == 0), (VEC[i].cls == 0) ? ea : 32'd0});
      chk("R11 read", {63'd0, re_b}, {63'd0, (cls_b == 0)});
      @(negedge clk);
      idle_inputs();
      chk(tag_of(int'(VEC[i].cls)), obs_a, exp_obs(int'(VEC[i].cls), VEC[i].rd, dat, VEC[i].cum, VEC[i].cvm));
      chk("R9 early", obs_b, 64'd0);
      @(negedge clk);
      chk(tag_of(cls_b), obs_b, exp_obs(cls_b, VEC[i].rd, dat, VEC[i].cum, VEC[i].cvm));
      chk("R10 pulse", obs_a, 64'd0);
    end

    // R2: wrong opcode
    issue = 1'b1; instr = {6'b110011, 5'd2, 5'd1, 5'd2, 1'b0, 10'd0}; opa = 32'h80;
    #1; chk("R2 read", {63'd0, re_a}, 64'd0);
    @(negedge clk); idle_inputs();
    chk("R2 opcode", obs_a, 64'd1);
    @(negedge clk);

    // R2: nonzero low field
    issue = 1'b1; instr = mk_instr(5'd2, 1'b0) | 32'h0000_0004; opa = 32'h80;
    #1; chk("R2 read", {63'd0, re_a}, 64'd0);
    @(negedge clk); idle_inputs();
    chk("R2 low bits", obs_a, 64'd1);
    @(negedge clk);

    // R10: no issue, no outputs, even with faults presented
    issue = 1'b0; instr = mk_instr(5'd3, 1'b0); opa = 32'h3; vm = 1'b1; tlb = 1'b1;
    #1; chk("R10 idle read", {62'd0, re_a, re_b}, 64'd0);
    @(negedge clk);
    chk("R10 idle", obs_a, 64'd0);
    @(negedge clk);
    chk("R10 idle", obs_b, 64'd0);
    idle_inputs();

    // R8 / R10: back-to-back fault then clean load
    issue = 1'b1; instr = mk_instr(5'd12, 1'b0); opa = 32'h7000; vm = 1'b1; tlb = 1'b1;
    @(negedge clk);
    chk("R4 b2b", obs_a, exp_obs(1, 5'd12, 32'd0, 1'b0, 1'b1));
    instr = mk_instr(5'd13, 1'b0); opa = 32'h7100; vm = 1'b0; tlb = 1'b0;
    #1; chk("R1 b2b read", {31'd0, re_a, addr_a}, {31'd0, 1'b1, 32'h7100});
    @(negedge clk); idle_inputs();
    chk("R8 R10 b2b", obs_a, exp_obs(0, 5'd13, memfn(32'h7100), 1'b0, 1'b0));
    @(negedge clk);
    chk("R10 b2b end", obs_a, 64'd0);

    finish_run();
  end

endmodule